// File: doc/BRIEF.md
# Frame-Synchronous PCM Tone Injector

This block sits in the outgoing PCM byte path of a conferencing circuit, ahead of the serializer. On each timeslot it either forwards the normal PCM byte or substitutes a companded square-wave tone. The substitution happens only when a tone is requested and the timeslot belongs to an enabled conference. The tone level is one tenth of the full-scale value. The tone polarity follows an external square-wave generator.

The tone request and the square-wave level are captured only on the frame pulse. As a result, every channel in a frame carries the same tone state and the same polarity. A request that changes in the middle of a frame takes effect at the next frame boundary.

Timeslots are counted from the frame pulse. The byte presented in the pulse cycle, or otherwise the first byte after the pulse, is slot 0. A per-slot membership map marks which slots belong to enabled conferences. A law-select input chooses between A-law and mu-law codes on each byte.

Top module: `tone_injector`

## Requirements
- R1: While reset is held, `pcm_out_valid` and `pcm_out` are 0. After reset is released, the captured tone request stays off until the first frame pulse, so all bytes pass through unchanged.
- R2: When the captured tone request is off, each byte reaches `pcm_out` unchanged, one clock after it is presented.
- R3: `tone_en_in` and `tone_sq_in` are captured only in a cycle with `frame_pulse` high. Changes to them between pulses have no effect on the output until the next pulse. A byte presented in the pulse cycle itself already uses the newly captured values.
- R4: A tone byte takes the positive code when the captured square-wave level is 1, and the negative code when it is 0.
- R5: With `law_sel` = 0 (A-law), the tone codes are 8'h9C (positive) and 8'h1C (negative). These are the A-law codes for a magnitude of one tenth of full scale.
- R6: With `law_sel` = 1 (mu-law), the tone codes are 8'hB5 (positive) and 8'h35 (negative). These are the mu-law codes for a magnitude of one tenth of full scale.
- R7: Bit i of `conf_map` marks slot i as a conference member. A byte in a slot whose bit is 0 passes through unchanged, even while the tone is on.
- R8: Bytes beyond slot NUM_SLOTS-1 within a frame are never replaced by the tone.
- R9: `pcm_out_valid` equals `pcm_valid` delayed by one clock. While it is 0, `pcm_out` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | Frame boundary strobe; captures the tone inputs and restarts slot counting |
| tone_en_in | input | 1 | Tone request, captured at frame pulses |
| tone_sq_in | input | 1 | Square-wave tone level from the external generator, captured at frame pulses |
| law_sel | input | 1 | Companding law: 0 = A-law, 1 = mu-law |
| conf_map | input | NUM_SLOTS | Per-slot conference membership |
| pcm_valid | input | 1 | A PCM byte is presented this cycle |
| pcm_in | input | 8 | Normal PCM byte |
| pcm_out_valid | output | 1 | Output byte valid |
| pcm_out | output | 8 | Selected byte (PCM or tone) |

## Verification
The bench builds the block with NUM_SLOTS = 8 and TONE_DIV = 10. The short slot count lets a frame overrun its last slot after a few bytes, which reaches the beyond-frame pass-through of R8 quickly. The default divider produces the four tone codes given in R5 and R6. The membership map is alternating and irregular, so member and non-member slots sit next to each other, including slot 0 and the last slot.

// File: rtl/tinj_pkg.sv
package tinj_pkg;

  localparam int PCM_W   = 8;
  localparam int A_FULL  = 4096;
  localparam int MU_FULL = 8159;

  typedef enum logic {
    LAW_A  = 1'b0,
    LAW_MU = 1'b1
  } law_e;

  // Linear magnitude of the tone for a given full scale and divider.
  function automatic int unsigned tone_mag(int unsigned full, int unsigned div);
    return full / div;
  endfunction

  // A-law: 13-bit sign-magnitude, segmented, even bits inverted.
  function automatic logic [7:0] alaw_code(int unsigned mag, logic positive);
    int unsigned m;
    logic [2:0]  seg;
    logic [3:0]  mant;
    m   = (mag > 4095) ? 4095 : mag;
    seg = 3'd0;
    for (int s = 1; s < 8; s++) begin
      if (m >= (32 << (s - 1))) seg = 3'(s);
    end
    if (seg == 3'd0) mant = 4'((m >> 1) & 15);
    else             mant = 4'((m >> seg) & 15);
    return {positive, seg, mant} ^ 8'h55;
  endfunction

  // mu-law: biased magnitude, segmented, all bits inverted.
  function automatic logic [7:0] mulaw_code(int unsigned mag, logic positive);
    int unsigned b;
    logic [2:0]  seg;
    logic [3:0]  mant;
    b   = ((mag > 8158) ? 8158 : mag) + 33;
    seg = 3'd0;
    for (int s = 1; s < 8; s++) begin
      if (b >= (64 << (s - 1))) seg = 3'(s);
    end
    mant = 4'((b >> (seg + 1)) & 15);
    return ~{~positive, seg, mant};
  endfunction

endpackage

// File: rtl/tinj_frame_latch.sv
module tinj_frame_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_pulse,
  input  logic tone_en_in,
  input  logic tone_sq_in,
  output logic en_q,
  output logic sq_q,
  output logic en_eff,
  output logic sq_eff
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      sq_q <= 1'b0;
    end else if (frame_pulse) begin
      en_q <= tone_en_in;
      sq_q <= tone_sq_in;
    end
  end

  // The byte in the pulse cycle already sees the new frame's values.
  always_comb begin
    en_eff = frame_pulse ? tone_en_in : en_q;
    sq_eff = frame_pulse ? tone_sq_in : sq_q;
  end

endmodule

// File: rtl/tinj_slot_track.sv
module tinj_slot_track #(
  parameter int NUM_SLOTS = 32,
  localparam int SLOT_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_pulse,
  input  logic                 pcm_valid,
  input  logic [NUM_SLOTS-1:0] conf_map,
  output logic [SLOT_W-1:0]    slot_now,
  output logic                 slot_in_frame,
  output logic                 slot_member
);

  localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(NUM_SLOTS);

  logic [SLOT_W-1:0] cnt_q;
  logic [SLOT_W-1:0] cnt_next;

  always_comb begin
    slot_now      = frame_pulse ? '0 : cnt_q;
    slot_in_frame = (slot_now < SLOT_END);
    slot_member   = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slot_now == SLOT_W'(i)) slot_member = conf_map[i];
    end
    cnt_next = cnt_q;
    if (frame_pulse)   cnt_next = '0;
    if (pcm_valid && slot_in_frame) cnt_next = slot_now + 1'b1;
  end

  // Counter parks at SLOT_END (outside any frame) after reset and after overrun.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= SLOT_END;
    else        cnt_q <= cnt_next;
  end

endmodule

// File: rtl/tinj_code_gen.sv
module tinj_code_gen
  import tinj_pkg::*;
#(
  parameter int TONE_DIV = 10
) (
  input  logic             law_sel,
  input  logic             positive,
  output logic [PCM_W-1:0] code
);

  localparam logic [PCM_W-1:0] A_POS  = alaw_code(tone_mag(A_FULL, TONE_DIV), 1'b1);
  localparam logic [PCM_W-1:0] A_NEG  = alaw_code(tone_mag(A_FULL, TONE_DIV), 1'b0);
  localparam logic [PCM_W-1:0] MU_POS = mulaw_code(tone_mag(MU_FULL, TONE_DIV), 1'b1);
  localparam logic [PCM_W-1:0] MU_NEG = mulaw_code(tone_mag(MU_FULL, TONE_DIV), 1'b0);

  always_comb begin
    unique case (law_e'(law_sel))
      LAW_A:   code = positive ? A_POS  : A_NEG;
      LAW_MU:  code = positive ? MU_POS : MU_NEG;
      default: code = A_POS;
    endcase
  end

endmodule

// File: rtl/tone_injector.sv
module tone_injector
  import tinj_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int TONE_DIV  = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_pulse,
  input  logic                 tone_en_in,
  input  logic                 tone_sq_in,
  input  logic                 law_sel,
  input  logic [NUM_SLOTS-1:0] conf_map,
  input  logic                 pcm_valid,
  input  logic [7:0]           pcm_in,
  output logic                 pcm_out_valid,
  output logic [7:0]           pcm_out
);

  localparam int SLOT_W = $clog2(NUM_SLOTS + 1);

  logic              en_q, sq_q, en_eff, sq_eff;
  logic [SLOT_W-1:0] slot_now;
  logic              slot_in_frame, slot_member;
  logic [PCM_W-1:0]  tone_code;
  logic              inject;

  tinj_frame_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_pulse(frame_pulse),
    .tone_en_in (tone_en_in),
    .tone_sq_in (tone_sq_in),
    .en_q       (en_q),
    .sq_q       (sq_q),
    .en_eff     (en_eff),
    .sq_eff     (sq_eff)
  );

  tinj_slot_track #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_pulse  (frame_pulse),
    .pcm_valid    (pcm_valid),
    .conf_map     (conf_map),
    .slot_now     (slot_now),
    .slot_in_frame(slot_in_frame),
    .slot_member  (slot_member)
  );

  tinj_code_gen #(.TONE_DIV(TONE_DIV)) u_code (
    .law_sel (law_sel),
    .positive(sq_eff),
    .code    (tone_code)
  );

  assign inject = pcm_valid && en_eff && slot_in_frame && slot_member;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcm_out_valid <= 1'b0;
      pcm_out       <= '0;
    end else begin
      pcm_out_valid <= pcm_valid;
      if (pcm_valid) pcm_out <= inject ? tone_code : pcm_in;
    end
  end

endmodule

// File: rtl/tone_injector_checker.sv
module tone_injector_checker
  import tinj_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int TONE_DIV  = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_pulse,
  input logic       law_sel,
  input logic       pcm_valid,
  input logic [7:0] pcm_in,
  input logic       pcm_out_valid,
  input logic [7:0] pcm_out,
  input logic       en_q,
  input logic       sq_q,
  input logic       sq_eff,
  input logic       slot_in_frame,
  input logic       slot_member,
  input logic       inject
);

  localparam logic [7:0] CA_P = alaw_code(tone_mag(A_FULL, TONE_DIV), 1'b1);
  localparam logic [7:0] CA_N = alaw_code(tone_mag(A_FULL, TONE_DIV), 1'b0);
  localparam logic [7:0] CM_P = mulaw_code(tone_mag(MU_FULL, TONE_DIV), 1'b1);
  localparam logic [7:0] CM_N = mulaw_code(tone_mag(MU_FULL, TONE_DIV), 1'b0);

  assert_reset_tone_off_R1: assert property (@(posedge clk)
    !rst_n |=> !en_q);

  assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_valid && !inject) |=> (pcm_out == $past(pcm_in)));

  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_pulse |=> ($stable(en_q) && $stable(sq_q)));

  assert_tone_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inject |=> (pcm_out == ($past(law_sel) ? ($past(sq_eff) ? CM_P : CM_N)
                                           : ($past(sq_eff) ? CA_P : CA_N))));

  assert_nonmember_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_member |-> !inject);

  assert_outside_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_in_frame |-> !inject);

  assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |=> pcm_out_valid);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_valid |=> (!pcm_out_valid && $stable(pcm_out)));

endmodule

bind tone_injector tone_injector_checker #(
  .NUM_SLOTS(NUM_SLOTS),
  .TONE_DIV (TONE_DIV)
) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_pulse  (frame_pulse),
  .law_sel      (law_sel),
  .pcm_valid    (pcm_valid),
  .pcm_in       (pcm_in),
  .pcm_out_valid(pcm_out_valid),
  .pcm_out      (pcm_out),
  .en_q         (en_q),
  .sq_q         (sq_q),
  .sq_eff       (sq_eff),
  .slot_in_frame(slot_in_frame),
  .slot_member  (slot_member),
  .inject       (inject)
);

// File: tb/tone_injector_bench.sv
module tone_injector_bench;

  localparam int NS = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_pulse = 1'b0;
  logic          tone_en_in = 1'b0;
  logic          tone_sq_in = 1'b0;
  logic          law_sel = 1'b0;
  logic [NS-1:0] conf_map = 8'b1010_0111;
  logic          pcm_valid = 1'b0;
  logic [7:0]    pcm_in = 8'h00;
  logic          pcm_out_valid;
  logic [7:0]    pcm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit   m_en = 1'b0;
  bit   m_sq = 1'b0;
  int   m_slot = NS;
  logic [7:0] last_exp = 8'h00;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  tone_injector #(.NUM_SLOTS(NS), .TONE_DIV(10)) u_tone_injector (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_pulse  (frame_pulse),
    .tone_en_in   (tone_en_in),
    .tone_sq_in   (tone_sq_in),
    .law_sel      (law_sel),
    .conf_map     (conf_map),
    .pcm_valid    (pcm_valid),
    .pcm_in       (pcm_in),
    .pcm_out_valid(pcm_out_valid),
    .pcm_out      (pcm_out)
  );

  function automatic logic [7:0] tone_byte(bit law, bit pos);
    if (!law) return pos ? 8'h9C : 8'h1C;
    return pos ? 8'hB5 : 8'h35;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Driver: one call per clock; models the expected byte and queues it.
  task automatic step(bit pulse, bit en, bit sq, bit law, bit valid,
                      logic [7:0] data, string tag);
    bit inj;
    logic [7:0] e;
    @(negedge clk);
    frame_pulse = pulse;
    tone_en_in  = en;
    tone_sq_in  = sq;
    law_sel     = law;
    pcm_valid   = valid;
    pcm_in      = data;
    if (pulse) begin
      m_en = en; m_sq = sq; m_slot = 0;
    end
    if (valid) begin
      inj = m_en && (m_slot < NS) && conf_map[m_slot];
      e   = inj ? tone_byte(law, m_sq) : data;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      last_exp = e;
      m_slot++;
    end
  endtask

  // Monitor: pops and compares each produced byte.
  always @(negedge clk) begin
    if (rst_n && pcm_out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9: unexpected output %02h expected none", pcm_out);
      end else begin
        check(tag_q.pop_front(), pcm_out, exp_q.pop_front());
      end
    end
  end

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {7'd0, pcm_out_valid}, 8'h00);
    check("R1 reset data", pcm_out, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // Tone requested but no frame pulse yet: pass through (R1).
    for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 1, 8'hA0 + 8'(i), "R1");

    // Tone off: plain pass through (R2).
    step(1, 0, 1, 0, 0, 8'h00, "R2");
    for (int i = 0; i < NS; i++) step(0, 0, 1, 0, 1, 8'h40 + 8'(i), "R2");

    // A-law positive tone; request inputs drop mid-frame (R3, R5, R7, R8).
    step(1, 1, 1, 0, 0, 8'h00, "R5");
    for (int i = 0; i < NS + 2; i++)
      step(0, i < 3, i < 3, 0, 1, 8'h10 + 8'(i), i >= NS ? "R8" : "R5 R7 R3");

    // A-law negative tone (R4).
    step(1, 1, 0, 0, 0, 8'h00, "R4");
    for (int i = 0; i < NS; i++) step(0, 1, 0, 0, 1, 8'h60 + 8'(i), "R4 R5");

    // mu-law negative, byte in the pulse cycle is slot 0 (R3, R6).
    step(1, 1, 0, 1, 1, 8'h70, "R3 R6");
    for (int i = 1; i < NS + 1; i++) step(0, 0, 1, 1, 1, 8'h70 + 8'(i), "R6 R8");

    // mu-law positive with gaps between bytes (R4, R6, R9).
    step(1, 1, 1, 1, 0, 8'h00, "R6");
    for (int i = 0; i < NS; i++) begin
      step(0, 1, 1, 1, 1, 8'h80 + 8'(i), "R4 R6");
      step(0, 1, 1, 1, 0, 8'hEE, "R9");
    end

    // Tone stops at the pulse; pulse-cycle byte already passes (R3).
    step(1, 0, 1, 1, 1, 8'h90, "R3");
    for (int i = 1; i < NS; i++) step(0, 1, 1, 1, 1, 8'h90 + 8'(i), "R3 R2");

    // Idle: output holds (R9).
    step(0, 0, 0, 0, 0, 8'h55, "R9");
    repeat (3) begin
      @(negedge clk);
      check("R9 idle valid", {7'd0, pcm_out_valid}, 8'h00);
      check("R9 idle hold", pcm_out, last_exp);
    end
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    report();
  end

endmodule